// File: doc/BRIEF.md
# DMA Address Remapper with Line Read-Ahead

This block sits between a DMA-capable peripheral and the system memory bus. Each device request carries a 32-bit address. The block looks up that address in a small, fully associative table of 4 KB page mappings and sends the request on with a 36-bit system address. A device that can only form 32-bit addresses can therefore reach memory anywhere in a 64 GB space. Requests that match no mapping never reach memory. The device receives an error response for them instead.

Every mapping carries one attribute bit. With the bit clear, the mapping is consistent: each read goes to memory on demand and nothing is fetched early. Clear is the reset value and the value software gets unless it asks for more. With the bit set, the mapping is streaming. After a demand read has been answered, the block reads the next sequential line of the same page into a one-line buffer. The next read in a contiguous burst is then answered from that buffer, and the block starts fetching the line after it. The buffer is dropped whenever the table changes, and whenever the device writes the buffered line.

Software loads table entries through a simple write-only register port. The block keeps one request in flight and holds the device off while it is busy. Each device request receives exactly one response.

Top module: `dma_remap_top`

## Requirements
- R1: A read or write whose 20-bit device page matches a valid entry reaches memory at address {system page (24 bits), device address bits 11..3, 3'b000}. Address bits 2..0 are ignored. System pages with the top bits set reach above 4 GB. A read returns the 64-bit memory word with no error flag.
- R2: After reset, no entry is valid and the attribute of every entry is consistent (0). `dev_req_ready` is high, and no response or memory request is pending.
- R3: A request that matches no valid entry receives a response with `dev_rsp_err`=1 in the cycle after acceptance. It issues no memory request, whether it is a read or a write.
- R4: A read through a consistent mapping (`cfg_stream`=0) issues exactly one memory read and no read-ahead. Repeating the read goes to memory again.
- R5: A read through a streaming mapping (`cfg_stream`=1) that misses the buffer issues its demand read. After the response, it issues one read of the next line (system address + 8).
- R6: A streaming read whose line equals the buffered line is answered with the buffered data and issues no demand read. The only memory read that follows is the read-ahead of the next line.
- R7: Read-ahead is never issued from the last line of a 4 KB page (address bits 11..3 all ones).
- R8: Any write to the table invalidates the buffer. This includes a read-ahead still in flight, whose data is then discarded.
- R9: A device write is forwarded translated, with its data, and gets a response without error. If it hits the buffered line, the buffer is invalidated. A write to any other line leaves the buffer in place.
- R10: When several valid entries match the same device page, the entry with the lowest index is used.
- R11: `mem_req_valid`, `mem_req_addr` and `mem_req_write` stay constant while `mem_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | 3 | Entry index to write |
| cfg_valid | input | 1 | Valid bit for the entry |
| cfg_stream | input | 1 | Attribute: 1 streaming, 0 consistent |
| cfg_dev_page | input | 20 | Device page number |
| cfg_sys_page | input | 24 | System page number |
| dev_req_valid | input | 1 | Device request present |
| dev_req_ready | output | 1 | Block can accept a request |
| dev_req_write | input | 1 | 1 write, 0 read |
| dev_req_addr | input | 32 | Device byte address |
| dev_req_wdata | input | 64 | Write data |
| dev_rsp_valid | output | 1 | One-cycle response pulse |
| dev_rsp_err | output | 1 | Translation fault |
| dev_rsp_rdata | output | 64 | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 36 | Line-aligned system address |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Memory response pulse, in order |
| mem_rsp_rdata | input | 64 | Memory read data |

## Verification
The bench builds the block with its default parameters: eight entries, 4 KB pages and 64-bit lines, which gives 512 lines per page. At this size every table entry can be loaded and read through. A streaming burst can walk all 512 lines of one page, so each buffer hit, the step across every line and the page-end stop are all exercised. The memory model on the bench drops its ready signal one cycle in four, which lands stalls on demand reads, writes and read-aheads in turn.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int DEV_AW     = 32;
  localparam int PG_OFF_W   = 12;
  localparam int SPAGE_W    = 24;
  localparam int DATA_W     = 64;
  localparam int DPAGE_W    = DEV_AW - PG_OFF_W;
  localparam int SYS_AW     = SPAGE_W + PG_OFF_W;
  localparam int LINE_BYTES = DATA_W / 8;
  localparam int LINE_OFF_W = $clog2(LINE_BYTES);
  localparam int LINE_AW    = SYS_AW - LINE_OFF_W;

  typedef struct packed {
    logic               vld;
    logic               stream;
    logic [DPAGE_W-1:0] dpage;
    logic [SPAGE_W-1:0] spage;
  } map_ent_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DWAIT, ST_PREQ, ST_PWAIT
  } ctl_st_t;

  function automatic logic [DPAGE_W-1:0] dev_page(input logic [DEV_AW-1:0] a);
    return a[DEV_AW-1:PG_OFF_W];
  endfunction

  function automatic logic [SYS_AW-1:0] sys_line(input logic [SPAGE_W-1:0] sp,
                                                 input logic [DEV_AW-1:0] a);
    return {sp, a[PG_OFF_W-1:LINE_OFF_W], {LINE_OFF_W{1'b0}}};
  endfunction

  function automatic logic last_in_page(input logic [SYS_AW-1:0] a);
    return &a[PG_OFF_W-1:LINE_OFF_W];
  endfunction

  function automatic logic [SYS_AW-1:0] next_line(input logic [SYS_AW-1:0] a);
    return a + SYS_AW'(LINE_BYTES);
  endfunction
endpackage

// File: rtl/remap_table.sv
module remap_table import remap_pkg::*; #(
  parameter int N_ENT = 8,
  parameter int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  map_ent_t           cfg_ent,
  input  logic [DPAGE_W-1:0] lk_dpage,
  output logic               lk_hit,
  output logic               lk_stream,
  output logic [SPAGE_W-1:0] lk_spage
);
  map_ent_t         ents [N_ENT];
  logic [N_ENT-1:0] match;

  genvar g;
  generate
    for (g = 0; g < N_ENT; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (!rst_n) ents[g] <= '0;
        else if (cfg_we && cfg_idx == IDX_W'(g)) ents[g] <= cfg_ent;
      end
      assign match[g] = ents[g].vld && (ents[g].dpage == lk_dpage);
    end
  endgenerate

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    lk_hit    = 1'b0;
    lk_stream = 1'b0;
    lk_spage  = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit    = 1'b1;
        lk_stream = ents[i].stream;
        lk_spage  = ents[i].spage;
      end
    end
  end
endmodule

// File: rtl/line_buffer.sv
module line_buffer import remap_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inval,
  input  logic               fill,
  input  logic [LINE_AW-1:0] fill_line,
  input  logic [DATA_W-1:0]  fill_data,
  input  logic [LINE_AW-1:0] q_line,
  output logic               hit,
  output logic [DATA_W-1:0]  rdata
);
  logic               bvalid;
  logic [LINE_AW-1:0] btag;
  logic [DATA_W-1:0]  bdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid <= 1'b0;
      btag   <= '0;
      bdata  <= '0;
    end else if (inval) begin
      bvalid <= 1'b0;
    end else if (fill) begin
      bvalid <= 1'b1;
      btag   <= fill_line;
      bdata  <= fill_data;
    end
  end

  assign hit   = bvalid && (btag == q_line);
  assign rdata = bdata;

  a_r8_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> !bvalid);
  a_r6_fill_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && !inval) |=> (bvalid && bdata == $past(fill_data)));
endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl import remap_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               dev_req_valid,
  output logic               dev_req_ready,
  input  logic               dev_req_write,
  input  logic [DEV_AW-1:0]  dev_req_addr,
  input  logic [DATA_W-1:0]  dev_req_wdata,
  output logic               dev_rsp_valid,
  output logic               dev_rsp_err,
  output logic [DATA_W-1:0]  dev_rsp_rdata,
  input  logic               lk_hit,
  input  logic               lk_stream,
  input  logic [SPAGE_W-1:0] lk_spage,
  input  logic               buf_hit,
  input  logic [DATA_W-1:0]  buf_rdata,
  output logic               buf_inval,
  output logic               buf_fill,
  output logic [LINE_AW-1:0] buf_fill_line,
  output logic [DATA_W-1:0]  buf_fill_data,
  output logic [LINE_AW-1:0] buf_q_line,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [SYS_AW-1:0]  mem_req_addr,
  output logic [DATA_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [DATA_W-1:0]  mem_rsp_rdata
);
  ctl_st_t            st;
  logic [SYS_AW-1:0]  cur_addr, pf_addr, q_line;
  logic               cur_wr, cur_stream, pf_kill;
  logic [DATA_W-1:0]  cur_wdata;
  logic               rsp_v, rsp_err;
  logic [DATA_W-1:0]  rsp_data;

  // named internal events
  logic fire, evt_miss, evt_buf_serve, wr_overlap, evt_pf_issue, dwait_done;

  assign q_line        = sys_line(lk_spage, dev_req_addr);
  assign dev_req_ready = (st == ST_IDLE);
  assign fire          = dev_req_valid && dev_req_ready;
  assign evt_miss      = fire && !lk_hit;
  assign evt_buf_serve = fire && lk_hit && !dev_req_write && lk_stream && buf_hit;
  assign wr_overlap    = fire && lk_hit && dev_req_write && buf_hit;
  assign evt_pf_issue  = (st == ST_PREQ) && mem_req_ready;
  assign dwait_done    = (st == ST_DWAIT) && mem_rsp_valid;

  assign buf_q_line    = q_line[SYS_AW-1:LINE_OFF_W];
  assign buf_inval     = cfg_we || wr_overlap;
  assign buf_fill      = (st == ST_PWAIT) && mem_rsp_valid && !pf_kill && !cfg_we;
  assign buf_fill_line = pf_addr[SYS_AW-1:LINE_OFF_W];
  assign buf_fill_data = mem_rsp_rdata;

  assign mem_req_valid = (st == ST_DREQ) || (st == ST_PREQ);
  assign mem_req_write = (st == ST_DREQ) && cur_wr;
  assign mem_req_addr  = (st == ST_PREQ) ? pf_addr : cur_addr;
  assign mem_req_wdata = cur_wdata;

  assign dev_rsp_valid = rsp_v;
  assign dev_rsp_err   = rsp_err;
  assign dev_rsp_rdata = rsp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur_addr   <= '0;
      cur_wr     <= 1'b0;
      cur_wdata  <= '0;
      cur_stream <= 1'b0;
      pf_addr    <= '0;
      pf_kill    <= 1'b0;
      rsp_v      <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_v   <= 1'b0;
      pf_kill <= pf_kill | cfg_we;
      unique case (st)
        ST_IDLE: begin
          if (evt_miss) begin
            rsp_v    <= 1'b1;
            rsp_err  <= 1'b1;
            rsp_data <= '0;
          end else if (fire) begin
            cur_addr   <= q_line;
            cur_wr     <= dev_req_write;
            cur_wdata  <= dev_req_wdata;
            cur_stream <= lk_stream;
            if (evt_buf_serve) begin
              rsp_v    <= 1'b1;
              rsp_err  <= 1'b0;
              rsp_data <= buf_rdata;
              if (!last_in_page(q_line)) begin
                pf_addr <= next_line(q_line);
                pf_kill <= cfg_we;
                st      <= ST_PREQ;
              end
            end else begin
              st <= ST_DREQ;
            end
          end
        end
        ST_DREQ: if (mem_req_ready) st <= ST_DWAIT;
        ST_DWAIT: begin
          if (mem_rsp_valid) begin
            rsp_v    <= 1'b1;
            rsp_err  <= 1'b0;
            rsp_data <= cur_wr ? '0 : mem_rsp_rdata;
            if (!cur_wr && cur_stream && !last_in_page(cur_addr)) begin
              pf_addr <= next_line(cur_addr);
              pf_kill <= cfg_we;
              st      <= ST_PREQ;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_PREQ:  if (mem_req_ready) st <= ST_PWAIT;
        ST_PWAIT: if (mem_rsp_valid) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  a_r3_miss_err: assert property (@(posedge clk) disable iff (!rst_n)
    evt_miss |=> (dev_rsp_valid && dev_rsp_err && !mem_req_valid));
  a_r6_serve_from_buf: assert property (@(posedge clk) disable iff (!rst_n)
    evt_buf_serve |=> (dev_rsp_valid && !dev_rsp_err && dev_rsp_rdata == $past(buf_rdata)));
  a_r4_no_readahead: assert property (@(posedge clk) disable iff (!rst_n)
    (dwait_done && !cur_stream) |=> (st == ST_IDLE));
  a_r7_pf_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pf_issue |-> (pf_addr[SYS_AW-1:PG_OFF_W] == cur_addr[SYS_AW-1:PG_OFF_W]));
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
endmodule

// File: rtl/dma_remap_top.sv
module dma_remap_top import remap_pkg::*; #(
  parameter int N_ENT = 8,
  parameter int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_valid,
  input  logic               cfg_stream,
  input  logic [DPAGE_W-1:0] cfg_dev_page,
  input  logic [SPAGE_W-1:0] cfg_sys_page,
  input  logic               dev_req_valid,
  output logic               dev_req_ready,
  input  logic               dev_req_write,
  input  logic [DEV_AW-1:0]  dev_req_addr,
  input  logic [DATA_W-1:0]  dev_req_wdata,
  output logic               dev_rsp_valid,
  output logic               dev_rsp_err,
  output logic [DATA_W-1:0]  dev_rsp_rdata,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [SYS_AW-1:0]  mem_req_addr,
  output logic [DATA_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [DATA_W-1:0]  mem_rsp_rdata
);
  map_ent_t           cfg_ent;
  logic               lk_hit, lk_stream;
  logic [SPAGE_W-1:0] lk_spage;
  logic               buf_hit, buf_inval, buf_fill;
  logic [DATA_W-1:0]  buf_rdata, buf_fill_data;
  logic [LINE_AW-1:0] buf_fill_line, buf_q_line;

  assign cfg_ent.vld    = cfg_valid;
  assign cfg_ent.stream = cfg_stream;
  assign cfg_ent.dpage  = cfg_dev_page;
  assign cfg_ent.spage  = cfg_sys_page;

  remap_table #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_ent(cfg_ent), .lk_dpage(dev_page(dev_req_addr)),
    .lk_hit(lk_hit), .lk_stream(lk_stream), .lk_spage(lk_spage));

  line_buffer u_buf (
    .clk(clk), .rst_n(rst_n), .inval(buf_inval), .fill(buf_fill),
    .fill_line(buf_fill_line), .fill_data(buf_fill_data),
    .q_line(buf_q_line), .hit(buf_hit), .rdata(buf_rdata));

  remap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready),
    .dev_req_write(dev_req_write), .dev_req_addr(dev_req_addr),
    .dev_req_wdata(dev_req_wdata), .dev_rsp_valid(dev_rsp_valid),
    .dev_rsp_err(dev_rsp_err), .dev_rsp_rdata(dev_rsp_rdata),
    .lk_hit(lk_hit), .lk_stream(lk_stream), .lk_spage(lk_spage),
    .buf_hit(buf_hit), .buf_rdata(buf_rdata), .buf_inval(buf_inval),
    .buf_fill(buf_fill), .buf_fill_line(buf_fill_line),
    .buf_fill_data(buf_fill_data), .buf_q_line(buf_q_line),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata));
endmodule

// File: tb/dma_remap_top_test.sv
module dma_remap_top_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_valid, cfg_stream;
  logic [2:0]  cfg_idx;
  logic [19:0] cfg_dev_page;
  logic [23:0] cfg_sys_page;
  logic        dev_req_valid, dev_req_ready, dev_req_write;
  logic [31:0] dev_req_addr;
  logic [63:0] dev_req_wdata;
  logic        dev_rsp_valid, dev_rsp_err;
  logic [63:0] dev_rsp_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [35:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  dma_remap_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_valid(cfg_valid), .cfg_stream(cfg_stream),
    .cfg_dev_page(cfg_dev_page), .cfg_sys_page(cfg_sys_page),
    .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready),
    .dev_req_write(dev_req_write), .dev_req_addr(dev_req_addr),
    .dev_req_wdata(dev_req_wdata), .dev_rsp_valid(dev_rsp_valid),
    .dev_rsp_err(dev_rsp_err), .dev_rsp_rdata(dev_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata));

  // memory model: stalls one cycle in four, answers one cycle after accept
  function automatic logic [63:0] mword(input logic [35:0] a);
    return {a, 28'h5A5A5A5};
  endfunction

  function automatic logic [35:0] sline(input logic [23:0] sp, input logic [31:0] a);
    return {sp, a[11:3], 3'b000};
  endfunction

  logic [1:0]  rdy_ph = 2'd0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [35:0] rlog [16];
  logic [35:0] last_wr_addr = '0;
  logic [63:0] last_wr_data = '0;

  assign mem_req_ready = (rdy_ph != 2'd3);

  always @(posedge clk) begin
    rdy_ph        <= rdy_ph + 2'd1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      if (mem_req_write) begin
        wr_cnt        <= wr_cnt + 1;
        last_wr_addr  <= mem_req_addr;
        last_wr_data  <= mem_req_wdata;
        mem_rsp_rdata <= '0;
      end else begin
        rd_cnt            <= rd_cnt + 1;
        rlog[rd_cnt % 16] <= mem_req_addr;
        mem_rsp_rdata     <= mword(mem_req_addr);
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input bit v, input logic [19:0] dp,
                     input logic [23:0] sp, input bit st);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_valid = v;
    cfg_dev_page = dp; cfg_sys_page = sp; cfg_stream = st;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!dev_req_ready) @(negedge clk);
  endtask

  task automatic dev_op(input bit wr, input logic [31:0] a, input logic [63:0] wd,
                        input string tag, output logic [63:0] rd, output bit er);
    int n;
    @(negedge clk);
    while (!dev_req_ready) @(negedge clk);
    dev_req_valid = 1'b1; dev_req_write = wr; dev_req_addr = a; dev_req_wdata = wd;
    @(negedge clk);
    dev_req_valid = 1'b0;
    n = 0;
    while (!dev_rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    rd = dev_rsp_rdata;
    er = dev_rsp_err;
    if (!dev_rsp_valid) begin
      chk(1'b0, {tag, " response timeout"}, 64'h0, 64'h1);
      er = 1'b1;
    end
  endtask

  // read, wait for any read-ahead to finish, report memory reads caused
  task automatic rd(input logic [31:0] a, input string tag, output logic [63:0] d,
                    output bit er, output int delta, output logic [35:0] first);
    int s;
    s = rd_cnt;
    dev_op(1'b0, a, 64'h0, tag, d, er);
    wait_idle();
    delta = rd_cnt - s;
    first = rlog[s % 16];
  endtask

  initial begin
    #(CLK_NS * 150000);
    chk(1'b0, "watchdog expired", 64'h0, 64'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [35:0] fa, ex;
    bit          e;
    int          dl, s;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_valid = 1'b0; cfg_stream = 1'b0;
    cfg_dev_page = '0; cfg_sys_page = '0;
    dev_req_valid = 1'b0; dev_req_write = 1'b0; dev_req_addr = '0; dev_req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk(dev_req_ready === 1'b1 && dev_rsp_valid === 1'b0 && mem_req_valid === 1'b0,
        "R2 idle outputs after reset",
        {61'b0, dev_req_ready, dev_rsp_valid, mem_req_valid}, 64'h4);
    rd(32'h0010_0008, "R2", d, e, dl, fa);
    chk(e == 1'b1, "R2 empty table faults", 64'(e), 64'h1);
    chk(dl == 0, "R3 no memory read on fault", 64'(dl), 64'h0);

    // R1 and R4: every entry, consistent, several offsets
    for (int i = 0; i < 8; i++)
      cfg(i, 1'b1, 20'h00100 + 20'(i), 24'hF00000 + 24'(i) * 24'h012345, 1'b0);
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] a;
        logic [11:0] off;
        off = (k == 0) ? 12'h000 : (k == 1) ? 12'h00F : (k == 2) ? 12'hABC : 12'hFF8;
        a   = {20'h00100 + 20'(i), off};
        ex  = sline(24'hF00000 + 24'(i) * 24'h012345, a);
        rd(a, "R1", d, e, dl, fa);
        chk(e == 1'b0 && d == mword(ex), "R1 translated read data", d, mword(ex));
        chk(fa == ex, "R1 R11 memory address", 64'(fa), 64'(ex));
        chk(dl == 1, "R4 consistent single read", 64'(dl), 64'h1);
      end
    end
    rd(32'h0010_0040, "R4", d, e, dl, fa);
    chk(dl == 1, "R4 repeated read refetched", 64'(dl), 64'h1);

    // R3 miss for read and write
    rd(32'h0020_0000, "R3", d, e, dl, fa);
    chk(e == 1'b1 && dl == 0, "R3 read miss", {63'b0, e}, 64'h1);
    s = wr_cnt;
    dev_op(1'b1, 32'h0020_0010, 64'h1234, "R3", d, e);
    wait_idle();
    chk(e == 1'b1 && wr_cnt == s, "R3 write miss no memory write", 64'(wr_cnt - s), 64'h0);

    // R10 priority
    cfg(2, 1'b1, 20'h00300, 24'h111111, 1'b0);
    cfg(5, 1'b1, 20'h00300, 24'h222222, 1'b0);
    rd(32'h0030_0100, "R10", d, e, dl, fa);
    chk(fa == sline(24'h111111, 32'h0030_0100), "R10 lowest index used", 64'(fa),
        64'(sline(24'h111111, 32'h0030_0100)));
    cfg(2, 1'b0, 20'h00300, 24'h111111, 1'b0);
    rd(32'h0030_0100, "R10", d, e, dl, fa);
    chk(fa == sline(24'h222222, 32'h0030_0100), "R10 next index after clear", 64'(fa),
        64'(sline(24'h222222, 32'h0030_0100)));

    // R5 R6 R7 streaming walk over one whole page
    cfg(0, 1'b1, 20'h00400, 24'hABCDE0, 1'b1);
    s = rd_cnt;
    for (int j = 0; j < 512; j++) begin
      logic [31:0] a;
      a  = {20'h00400, 9'(j), 3'(j)};
      ex = sline(24'hABCDE0, a);
      rd(a, "R6", d, e, dl, fa);
      chk(e == 1'b0 && d == mword(ex), "R6 streaming read data", d, mword(ex));
      if (j == 0) begin
        chk(dl == 2, "R5 demand plus read-ahead", 64'(dl), 64'h2);
        chk(rlog[(s + 1) % 16] == ex + 36'd8, "R5 read-ahead is next line",
            64'(rlog[(s + 1) % 16]), 64'(ex + 36'd8));
      end else if (j < 511) begin
        chk(dl == 1 && fa == ex + 36'd8, "R6 hit issues only next read-ahead",
            64'(fa), 64'(ex + 36'd8));
      end else begin
        chk(dl == 0, "R7 no read-ahead past page end", 64'(dl), 64'h0);
      end
    end
    chk(rd_cnt - s == 512, "R6 total reads for a full page", 64'(rd_cnt - s), 64'd512);
    cfg(7, 1'b1, 20'h00777, 24'h000777, 1'b0);
    rd(32'h0040_0FF8, "R7", d, e, dl, fa);
    chk(dl == 1, "R7 last-line demand only", 64'(dl), 64'h1);

    // R8 table write invalidates, idle and in flight
    rd(32'h0040_0050, "R8", d, e, dl, fa);
    cfg(7, 1'b1, 20'h00777, 24'h000778, 1'b0);
    rd(32'h0040_0058, "R8", d, e, dl, fa);
    chk(dl == 2 && fa == sline(24'hABCDE0, 32'h0040_0058), "R8 buffer dropped by table write",
        64'(dl), 64'h2);
    dev_op(1'b0, 32'h0040_0100, 64'h0, "R8", d, e);
    cfg(7, 1'b1, 20'h00777, 24'h000779, 1'b0);
    wait_idle();
    rd(32'h0040_0108, "R8", d, e, dl, fa);
    chk(dl == 2, "R8 in-flight read-ahead discarded", 64'(dl), 64'h2);

    // R9 device writes
    rd(32'h0040_0200, "R9", d, e, dl, fa);
    s = wr_cnt;
    dev_op(1'b1, 32'h0040_0208, 64'hDEAD_BEEF_0123_4567, "R9", d, e);
    wait_idle();
    chk(e == 1'b0 && wr_cnt == s + 1, "R9 write acknowledged", 64'(wr_cnt - s), 64'h1);
    chk(last_wr_addr == sline(24'hABCDE0, 32'h0040_0208) &&
        last_wr_data == 64'hDEAD_BEEF_0123_4567, "R9 write translated with data",
        64'(last_wr_addr), 64'(sline(24'hABCDE0, 32'h0040_0208)));
    rd(32'h0040_0208, "R9", d, e, dl, fa);
    chk(dl == 2, "R9 overlapping write drops buffer", 64'(dl), 64'h2);
    rd(32'h0040_0300, "R9", d, e, dl, fa);
    dev_op(1'b1, 32'h0040_0328, 64'h55, "R9", d, e);
    wait_idle();
    rd(32'h0040_0308, "R9", d, e, dl, fa);
    chk(dl == 1 && d == mword(sline(24'hABCDE0, 32'h0040_0308)),
        "R9 other-line write keeps buffer", 64'(dl), 64'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule